// File: doc/BRIEF.md
# Four-Mode Gated Timer/Counter

This block is a general-purpose timer/counter for a small microcontroller subsystem. It keeps two 8-bit count registers, a low byte and a high byte, that software loads over a simple write-only register bus and that are visible on output ports at all times. A two-bit mode field arranges the two bytes as a 13-bit counter with a 5-bit prescaler, a full 16-bit counter, an 8-bit counter that reloads itself from the high byte, or two independent 8-bit counters.

Each count step comes either from an internal machine-cycle tick or from a rising edge on an external count pin. A run bit starts and stops counting. An optional gate makes counting also wait on an external gate pin being high. When the main counter wraps, the block raises a sticky flag and emits a one-cycle overflow pulse for neighbouring peripherals. In split mode the high byte runs as a separate tick counter. It is started by a second run input and has its own flag.

Top module: `tmr_unit`

## Requirements
- R1: While rst is high, and after it falls, the low byte, high byte, both flags and the overflow pulse read 0, and the mode, source, gate and run settings are 0.
- R2: Mode 0 (mode field 00): each count adds one to the low byte. When the low byte's bits [4:0] are all ones, the count clears the whole low byte and adds one to the high byte. When the high byte goes from 0xFF to 0x00, the main flag is set.
- R3: Mode 1 (mode field 01): the two bytes form one 16-bit counter with the low byte as the least significant byte. A wrap from 0xFFFF to 0x0000 sets the main flag.
- R4: Mode 2 (mode field 10): only the low byte counts. A count at 0xFF loads the low byte with the current high byte and sets the main flag.
- R5: Mode 3 (mode field 11): the low byte counts as an 8-bit counter under the main run, gate and source controls and sets the main flag on wrap. The high byte adds one on every tick while run2 is high, regardless of the main controls, and sets the second flag on wrap without any overflow pulse.
- R6: While the run bit (control register, address 3, bit 0) is 0, the main counter does not change except by register writes.
- R7: When the gate bit (mode register, address 2, bit 3) is 1, counting also requires the synchronized gatePin to be high. The gate pin passes through a two-flop synchronizer.
- R8: When the source bit (mode register, bit 2) is 1, each rising edge of cntPin gives exactly one count, seen after a two-flop synchronizer, and tick is ignored. When the source bit is 0, each cycle with tick high gives one count.
- R9: An edge detected while counting is held off (run clear or gate low) is kept pending and is applied once counting is enabled. A write to the mode register or to the control register discards it.
- R10: Every main-counter wrap raises ovfPulse for exactly the following cycle and sets flagOut. flagOut stays set until a control-register write puts 0 in bit 1, and a wrap in the same cycle as that write leaves it set. Bit 2 of the control register clears the second flag in the same way.
- R11: Bus writes go to address 0 (low byte), 1 (high byte), 2 (mode: bits [1:0] mode, bit 2 source, bit 3 gate) and 3 (control: bit 0 run, bit 1 main flag, bit 2 second flag). A byte write takes priority over a count in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Internal machine-cycle count enable |
| cntPin | input | 1 | External count pin, asynchronous |
| gatePin | input | 1 | External gate pin, asynchronous |
| run2 | input | 1 | Run enable for the high byte in split mode |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 2 | Register write address |
| wrData | input | 8 | Register write data |
| lowOut | output | 8 | Current low byte |
| highOut | output | 8 | Current high byte |
| flagOut | output | 1 | Main overflow flag |
| flag2Out | output | 1 | Split-mode high-byte flag |
| ovfPulse | output | 1 | One-cycle overflow event |

## Verification
The assertions assume that tick, run2 and the bus inputs are synchronous to clk. They also assume that the control logic only produces a high-byte step in split mode, so the datapath sees such a step only there. The bench drives every input on the falling edge. It holds cntPin and gatePin steady for several cycles after each change so that the synchronizers settle before it samples. It keeps tick low while it writes configuration, so the count values it expects depend only on the tick cycles it issues deliberately.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  parameter int CNT_W  = 8;
  parameter int PRE_W  = 5;
  parameter int SYNC_N = 2;
  parameter int ADDR_W = 2;

  localparam logic [ADDR_W-1:0] ADDR_LOW  = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_HIGH = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_CFG  = 2'd2;
  localparam logic [ADDR_W-1:0] ADDR_CTL  = 2'd3;

  typedef enum logic [1:0] {
    MODE_PRE    = 2'd0,
    MODE_WIDE   = 2'd1,
    MODE_RELOAD = 2'd2,
    MODE_SPLIT  = 2'd3
  } mode_e;

  typedef struct packed {
    logic             wrLow;
    logic             wrHigh;
    logic [CNT_W-1:0] data;
    mode_e            mode;
    logic             stepMain;
    logic             stepHigh;
  } strobe_t;
endpackage

// File: rtl/tmr_ctrl.sv
module tmr_ctrl
  import tmr_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              cntPin,
  input  logic              gatePin,
  input  logic              run2,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [CNT_W-1:0]  wrData,
  input  logic              wrapMain,
  input  logic              wrapHigh,
  output strobe_t           strobe,
  output logic              flagOut,
  output logic              flag2Out,
  output logic              ovfPulse
);
  logic [SYNC_N-1:0] cntSync, gateSync;
  logic cntLast, pendEdge;
  logic runQ, gateQ, srcQ;
  mode_e modeQ;
  logic cfgWr, ctlWr, rise, enable, gateOk;

  assign cfgWr  = wrEn && (wrAddr == ADDR_CFG);
  assign ctlWr  = wrEn && (wrAddr == ADDR_CTL);
  assign rise   = cntSync[SYNC_N-1] && !cntLast;
  assign gateOk = !gateQ || gateSync[SYNC_N-1];
  assign enable = runQ && gateOk;

  always_comb begin
    strobe.wrLow    = wrEn && (wrAddr == ADDR_LOW);
    strobe.wrHigh   = wrEn && (wrAddr == ADDR_HIGH);
    strobe.data     = wrData;
    strobe.mode     = modeQ;
    strobe.stepMain = enable && (srcQ ? (rise || pendEdge) : tick);
    strobe.stepHigh = (modeQ == MODE_SPLIT) && run2 && tick;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cntSync  <= '0;
      gateSync <= '0;
      cntLast  <= 1'b0;
      pendEdge <= 1'b0;
      runQ     <= 1'b0;
      gateQ    <= 1'b0;
      srcQ     <= 1'b0;
      modeQ    <= MODE_PRE;
      flagOut  <= 1'b0;
      flag2Out <= 1'b0;
      ovfPulse <= 1'b0;
    end else begin
      cntSync  <= {cntSync[SYNC_N-2:0], cntPin};
      gateSync <= {gateSync[SYNC_N-2:0], gatePin};
      cntLast  <= cntSync[SYNC_N-1];
      if (cfgWr) begin
        modeQ <= mode_e'(wrData[1:0]);
        srcQ  <= wrData[2];
        gateQ <= wrData[3];
      end
      if (ctlWr) runQ <= wrData[0];
      if (cfgWr || ctlWr) pendEdge <= 1'b0;
      else pendEdge <= (pendEdge || rise) && !(enable && srcQ);
      if (wrapMain)   flagOut <= 1'b1;
      else if (ctlWr) flagOut <= wrData[1];
      if (wrapHigh)   flag2Out <= 1'b1;
      else if (ctlWr) flag2Out <= wrData[2];
      ovfPulse <= wrapMain;
    end
  end

  p_flag_after_wrap_r10: assert property (@(posedge clk) disable iff (rst)
    wrapMain |=> flagOut);
  p_pulse_with_flag_r10: assert property (@(posedge clk) disable iff (rst)
    ovfPulse |-> flagOut);
  p_flag2_after_wrap_r5: assert property (@(posedge clk) disable iff (rst)
    wrapHigh |=> flag2Out);
  p_no_step_stopped_r6: assert property (@(posedge clk) disable iff (rst)
    !runQ |-> !strobe.stepMain);
  p_high_split_only_r5: assert property (@(posedge clk) disable iff (rst)
    strobe.stepHigh |-> (strobe.mode == MODE_SPLIT));
endmodule

// File: rtl/tmr_datapath.sv
module tmr_datapath
  import tmr_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  strobe_t          strobe,
  output logic [CNT_W-1:0] lowQ,
  output logic [CNT_W-1:0] highQ,
  output logic             wrapMain,
  output logic             wrapHigh
);
  logic [CNT_W-1:0] lowNext, highNext;
  logic lowFull, highFull, preFull;

  assign lowFull  = &lowQ;
  assign highFull = &highQ;
  assign preFull  = &lowQ[PRE_W-1:0];

  always_comb begin
    lowNext  = lowQ;
    highNext = highQ;
    wrapMain = 1'b0;
    wrapHigh = 1'b0;
    if (strobe.stepMain) begin
      case (strobe.mode)
        MODE_PRE: begin
          if (preFull) begin
            lowNext  = '0;
            highNext = highQ + 1'b1;
            wrapMain = highFull;
          end else begin
            lowNext = lowQ + 1'b1;
          end
        end
        MODE_WIDE: begin
          lowNext = lowQ + 1'b1;
          if (lowFull) begin
            highNext = highQ + 1'b1;
            wrapMain = highFull;
          end
        end
        MODE_RELOAD: begin
          if (lowFull) begin
            lowNext  = highQ;
            wrapMain = 1'b1;
          end else begin
            lowNext = lowQ + 1'b1;
          end
        end
        default: begin
          lowNext  = lowQ + 1'b1;
          wrapMain = lowFull;
        end
      endcase
    end
    if (strobe.stepHigh) begin
      highNext = highQ + 1'b1;
      wrapHigh = highFull;
    end
    if (strobe.wrLow)  lowNext  = strobe.data;
    if (strobe.wrHigh) highNext = strobe.data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lowQ  <= '0;
      highQ <= '0;
    end else begin
      lowQ  <= lowNext;
      highQ <= highNext;
    end
  end

  p_hold_idle_r6: assert property (@(posedge clk) disable iff (rst)
    (!strobe.stepMain && !strobe.stepHigh && !strobe.wrLow && !strobe.wrHigh)
    |=> ($stable(lowQ) && $stable(highQ)));
  p_reload_r4: assert property (@(posedge clk) disable iff (rst)
    (strobe.stepMain && strobe.mode == MODE_RELOAD && lowFull && !strobe.wrLow)
    |=> (lowQ == $past(highQ)));
  p_low_write_r11: assert property (@(posedge clk) disable iff (rst)
    strobe.wrLow |=> (lowQ == $past(strobe.data)));
endmodule

// File: rtl/tmr_unit.sv
module tmr_unit
  import tmr_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              cntPin,
  input  logic              gatePin,
  input  logic              run2,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [CNT_W-1:0]  wrData,
  output logic [CNT_W-1:0]  lowOut,
  output logic [CNT_W-1:0]  highOut,
  output logic              flagOut,
  output logic              flag2Out,
  output logic              ovfPulse
);
  strobe_t strobe;
  logic wrapMain, wrapHigh;

  tmr_ctrl i_ctrl (
    .clk(clk), .rst(rst), .tick(tick), .cntPin(cntPin), .gatePin(gatePin),
    .run2(run2), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .wrapMain(wrapMain), .wrapHigh(wrapHigh), .strobe(strobe),
    .flagOut(flagOut), .flag2Out(flag2Out), .ovfPulse(ovfPulse)
  );

  tmr_datapath i_dp (
    .clk(clk), .rst(rst), .strobe(strobe), .lowQ(lowOut), .highQ(highOut),
    .wrapMain(wrapMain), .wrapHigh(wrapHigh)
  );
endmodule

// File: tb/test_tmr_unit.sv
module test_tmr_unit;
  logic clk = 1'b0, rst = 1'b1, tick = 1'b0, cntPin = 1'b0, gatePin = 1'b0;
  logic run2 = 1'b0, wrEn = 1'b0;
  logic [1:0] wrAddr = 2'd0;
  logic [7:0] wrData = 8'd0;
  logic [7:0] lowOut, highOut;
  logic flagOut, flag2Out, ovfPulse;
  int nRun = 0, nFail = 0, pulseCnt = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  tmr_unit i_tmr_unit (
    .clk(clk), .rst(rst), .tick(tick), .cntPin(cntPin), .gatePin(gatePin),
    .run2(run2), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .lowOut(lowOut), .highOut(highOut), .flagOut(flagOut),
    .flag2Out(flag2Out), .ovfPulse(ovfPulse)
  );

  always @(posedge clk) begin
    #2;
    if (!rst && ovfPulse) pulseCnt++;
  end

  task automatic check(input string req, input int act, input int exp);
    nRun++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk); wrEn = 1'b0;
  endtask

  task automatic ticks(input int n);
    @(negedge clk); tick = 1'b1;
    repeat (n) @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic setup(input logic [7:0] lo, input logic [7:0] hi, input logic [7:0] cfg, input logic [7:0] ctl);
    wr(2'd3, 8'h00);
    wr(2'd0, lo);
    wr(2'd1, hi);
    wr(2'd2, cfg);
    wr(2'd3, ctl);
  endtask

  task automatic t_reset();
    check("R1 low", lowOut, 0);
    check("R1 high", highOut, 0);
    check("R1 flags", {flagOut, flag2Out, ovfPulse}, 0);
    ticks(3);
    check("R1 run cleared by reset", lowOut, 0);
  endtask

  task automatic t_prescale();
    int p0;
    setup(8'hFE, 8'h10, 8'h00, 8'h01);
    ticks(1);
    check("R2 low step", lowOut, 8'hFF);
    ticks(1);
    check("R2 prescaler clear low", lowOut, 0);
    check("R2 high carry", highOut, 8'h11);
    check("R2 no flag", flagOut, 0);
    setup(8'h1F, 8'hFF, 8'h00, 8'h01);
    p0 = pulseCnt;
    ticks(1);
    idle(1);
    check("R2 wrap low", lowOut, 0);
    check("R2 wrap high", highOut, 0);
    check("R2 flag", flagOut, 1);
    check("R10 one pulse mode0", pulseCnt - p0, 1);
  endtask

  task automatic t_wide();
    int p0;
    setup(8'hFE, 8'h00, 8'h01, 8'h01);
    ticks(2);
    check("R3 carry into high", {highOut, lowOut}, 16'h0100);
    setup(8'hFE, 8'hFF, 8'h01, 8'h01);
    p0 = pulseCnt;
    ticks(1);
    check("R3 no flag before wrap", flagOut, 0);
    ticks(1);
    idle(1);
    check("R3 wrap value", {highOut, lowOut}, 0);
    check("R3 flag", flagOut, 1);
    check("R10 one pulse mode1", pulseCnt - p0, 1);
  endtask

  task automatic t_reload();
    int p0;
    setup(8'hFE, 8'h80, 8'h02, 8'h01);
    p0 = pulseCnt;
    ticks(2);
    check("R4 reload value", lowOut, 8'h80);
    check("R4 high unchanged", highOut, 8'h80);
    check("R4 flag", flagOut, 1);
    ticks(128);
    idle(1);
    check("R4 second reload", lowOut, 8'h80);
    check("R4 pulses", pulseCnt - p0, 2);
  endtask

  task automatic t_split();
    int p0;
    setup(8'hFE, 8'hFE, 8'h03, 8'h01);
    run2 = 1'b1;
    p0 = pulseCnt;
    ticks(2);
    idle(1);
    check("R5 low wrap", lowOut, 0);
    check("R5 high wrap", highOut, 0);
    check("R5 flags", {flagOut, flag2Out}, 2'b11);
    check("R5 high wrap gives no pulse", pulseCnt - p0, 1);
    wr(2'd3, 8'h00);
    ticks(3);
    check("R5 low stopped", lowOut, 0);
    check("R5 high runs on run2", highOut, 3);
    run2 = 1'b0;
    ticks(2);
    check("R5 high stops without run2", highOut, 3);
  endtask

  task automatic t_run();
    setup(8'h40, 8'h07, 8'h01, 8'h00);
    ticks(5);
    check("R6 held while stopped", {highOut, lowOut}, 16'h0740);
  endtask

  task automatic t_gate();
    gatePin = 1'b0;
    setup(8'h00, 8'h00, 8'h09, 8'h01);
    idle(3);
    ticks(3);
    check("R7 gate low blocks", lowOut, 0);
    gatePin = 1'b1;
    idle(3);
    ticks(3);
    check("R7 gate high counts", lowOut, 3);
    gatePin = 1'b0;
  endtask

  task automatic t_counter();
    cntPin = 1'b0;
    setup(8'h00, 8'h00, 8'h05, 8'h01);
    idle(4);
    ticks(5);
    check("R8 tick ignored", lowOut, 0);
    cntPin = 1'b1;
    idle(5);
    check("R8 one count per edge", lowOut, 1);
    idle(5);
    check("R8 high level no count", lowOut, 1);
    cntPin = 1'b0; idle(4);
    cntPin = 1'b1; idle(5);
    check("R8 second edge", lowOut, 2);
    cntPin = 1'b0; idle(4);
  endtask

  task automatic t_pending();
    gatePin = 1'b0; cntPin = 1'b0;
    setup(8'h00, 8'h00, 8'h0D, 8'h01);
    idle(4);
    cntPin = 1'b1; idle(5);
    check("R9 held by gate", lowOut, 0);
    gatePin = 1'b1; idle(5);
    check("R9 pending applied", lowOut, 1);
    gatePin = 1'b0; cntPin = 1'b0; idle(4);
    cntPin = 1'b1; idle(5);
    wr(2'd3, 8'h01);
    gatePin = 1'b1; idle(5);
    check("R9 control write discards", lowOut, 1);
    gatePin = 1'b0; cntPin = 1'b0; idle(4);
    cntPin = 1'b1; idle(5);
    wr(2'd2, 8'h0D);
    gatePin = 1'b1; idle(5);
    check("R9 mode write discards", lowOut, 1);
    gatePin = 1'b0; cntPin = 1'b0; idle(4);
  endtask

  task automatic t_flag();
    setup(8'hFF, 8'hFF, 8'h01, 8'h01);
    @(negedge clk);
    tick = 1'b1; wrEn = 1'b1; wrAddr = 2'd3; wrData = 8'h01;
    @(negedge clk);
    tick = 1'b0; wrEn = 1'b0;
    check("R10 pulse high", ovfPulse, 1);
    check("R10 set beats clear", flagOut, 1);
    idle(1);
    check("R10 pulse one cycle", ovfPulse, 0);
    idle(3);
    check("R10 sticky", flagOut, 1);
    wr(2'd3, 8'h01);
    check("R10 software clear", flagOut, 0);
  endtask

  task automatic t_bus();
    setup(8'h10, 8'h20, 8'h01, 8'h01);
    @(negedge clk);
    tick = 1'b1; wrEn = 1'b1; wrAddr = 2'd0; wrData = 8'hA5;
    @(negedge clk);
    tick = 1'b0; wrEn = 1'b0;
    check("R11 write beats count", lowOut, 8'hA5);
    wr(2'd1, 8'h5A);
    check("R11 high write", highOut, 8'h5A);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_prescale();
    t_wide();
    t_reload();
    t_split();
    t_run();
    t_gate();
    t_counter();
    t_pending();
    t_flag();
    t_bus();
    if (!finished) begin
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      nRun++; nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end
endmodule